// File: doc/BRIEF.md
# 8-bit Waveform Generation Timer

An 8-bit up or up/down counter that advances by one step on every cycle in which the external count-enable tick is high. The prescaler sits outside the block. A three-bit mode field selects one of four counting schemes: free-running, clear on compare A, single-slope PWM and dual-slope PWM. The mode also decides where the counter turns around, when new compare values become active and where the overflow event is raised.

Two compare channels, A and B, each drive one output pin. A two-bit output-mode field per channel sets how the pin responds to compare matches and to the counter's turning points. Three event flags (overflow, match A, match B) are kept in the block. Each flag has a mask bit, and the masked flags are ORed into one interrupt request. Software loads the counter, the compare values, the control fields and the mask through one write port. It clears flags through a separate write-1-to-clear port.

Top module: `wavetimer8`

## Requirements
- R1: While and after reset, count is 0x00, all three flags are 0, both output pins are 0 and irq is 0.
- R2: In free-running mode (mode field 000), each tick adds one to the count and wraps 0xFF to 0x00. The count holds in any cycle without a tick or a write. The tick taken at 0xFF sets the overflow flag (flags bit 0).
- R3: In clear-on-compare mode (010), a tick taken while count equals active compare A loads 0x00. A tick taken while count equals compare A sets flags bit 1, and a tick taken while count equals compare B sets flags bit 2. Overflow sets only on a tick taken at 0xFF.
- R4: In single-slope PWM, TOP is 0xFF for mode 011 and active compare A for mode 111. The tick taken at TOP loads 0x00 and sets the overflow flag.
- R5: In dual-slope PWM, TOP is 0xFF for mode 001 and active compare A for mode 101. The count rises to TOP and then falls to 0x00. Each turning point is visited once. The tick taken at 0x00 while falling sets the overflow flag and turns the count upward. A control write restarts the direction as upward.
- R6: A compare write takes effect at once in modes 000 and 010. In single-slope PWM it is held until the tick taken at TOP. In dual-slope PWM it is held until the tick on which the count turns down at TOP.
- R7: In modes 000 and 010, a match on a channel toggles its pin when the output field is 01, clears it when 10 and sets it when 11. Output field 00 drives the pin to 0 but keeps the pin state. Re-enabling the field shows that state again.
- R8: In single-slope PWM with output field 10, the pin sets on the tick at TOP and clears on a match tick. Field 11 inverts both actions. Field 01 drives the pin to 0.
- R9: In dual-slope PWM with output field 10, a match while rising clears the pin and a match while falling sets it. Field 11 inverts both.
- R10: Mode codes 100 and 110 hold the count and raise no flag while ticks arrive.
- R11: Flags set only on tick events. Writing 1 to a bit of clr_bits with clr_en clears that flag. A set event in the same cycle wins over the clear.
- R12: irq is high exactly when some flag is 1 and its mask bit is 1.
- R13: A count write in the same cycle as a tick loads the written value, and that tick raises no flag and no pin change.
- R14: Write port select values: 0 is the count, 1 is compare A, 2 is compare B, 3 is control and 4 is the mask. Control holds mode [2:0], channel A output field [4:3] and channel B output field [6:5]. The mask uses bits [2:0] in the same order as flags: bit 0 overflow, bit 1 match A, bit 2 match B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable from the external prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | W | Write data |
| clr_en | input | 1 | Flag clear strobe |
| clr_bits | input | 3 | Flags to clear, one bit each |
| count | output | W | Current count |
| out_a | output | 1 | Compare channel A pin |
| out_b | output | 1 | Compare channel B pin |
| flags | output | 3 | Overflow, match A and match B flags |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach from the ports is a buffered compare value that stays pending while the old value still controls the matches and the turning point. Its effect is only visible later, at TOP or at the wrap. The stimulus writes the new value in the middle of a run. It first confirms that the old value still produces a match or sets the turning point. It then steps the count through the load point and shows that the new value now governs.

// File: rtl/wavetimer8.sv
module wavetimer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         clr_en,
  input  logic [2:0]   clr_bits,
  output logic [W-1:0] count,
  output logic         out_a,
  output logic         out_b,
  output logic [2:0]   flags,
  output logic         irq
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt, buf_a, buf_b, act_a, act_b, top, cnt_nx;
  logic [2:0]   mode, mask, flg;
  logic [1:0]   om_a, om_b;
  logic         down, down_nx, q_a, q_b;

  wire is_pc   = (mode == 3'd1) || (mode == 3'd5);
  wire is_fast = (mode == 3'd3) || (mode == 3'd7);
  wire is_np   = (mode == 3'd0) || (mode == 3'd2);
  wire pwm     = is_pc || is_fast;
  wire cnt_wr  = wr_en && (wr_sel == 3'd0);
  wire ctl_wr  = wr_en && (wr_sel == 3'd3);
  wire step    = tick && (pwm || is_np) && !cnt_wr;

  assign top = ((mode == 3'd2) || (mode == 3'd5) || (mode == 3'd7)) ? act_a : MAXV;
  wire at_top = (cnt == top);

  wire ovf_ev = step && (is_pc ? (down && cnt == '0) : is_fast ? at_top : (cnt == MAXV));
  wire hit_a  = step && (cnt == act_a);
  wire hit_b  = step && (cnt == act_b);
  wire wrap   = step && is_fast && at_top;
  wire load   = step && (is_fast ? at_top : is_pc && !down && (cnt >= top));

  always_comb begin
    cnt_nx  = cnt + 1'b1;
    down_nx = down;
    if (is_pc) begin
      if (top == '0) cnt_nx = '0;
      else if (!down && cnt >= top) begin
        cnt_nx  = cnt - 1'b1;
        down_nx = 1'b1;
      end else if (down && cnt == '0) begin
        cnt_nx  = cnt + 1'b1;
        down_nx = 1'b0;
      end else if (down) cnt_nx = cnt - 1'b1;
    end else if ((mode == 3'd2 || is_fast) && at_top) begin
      cnt_nx = '0;
    end
  end

  function automatic logic pin_next(input logic q, input logic [1:0] om, input logic hit,
                                    input logic wr, input logic dn, input logic pcm,
                                    input logic fst);
    logic nx;
    nx = q;
    if (fst) begin
      if (wr) nx = (om == 2'b10) ? 1'b1 : (om == 2'b11) ? 1'b0 : q;
      else if (hit) nx = (om == 2'b10) ? 1'b0 : (om == 2'b11) ? 1'b1 : q;
    end else if (pcm) begin
      if (hit && om[1]) nx = om[0] ^ dn;
    end else if (hit) begin
      case (om)
        2'b01:   nx = ~q;
        2'b10:   nx = 1'b0;
        2'b11:   nx = 1'b1;
        default: nx = q;
      endcase
    end
    return nx;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      buf_a <= '0;
      buf_b <= '0;
      act_a <= '0;
      act_b <= '0;
      mode  <= '0;
      om_a  <= '0;
      om_b  <= '0;
      mask  <= '0;
      flg   <= '0;
      down  <= 1'b0;
      q_a   <= 1'b0;
      q_b   <= 1'b0;
    end else begin
      if (cnt_wr) cnt <= wr_data;
      else if (step) cnt <= cnt_nx;

      if (ctl_wr) down <= 1'b0;
      else if (step && is_pc) down <= down_nx;

      if (ctl_wr) begin
        mode <= wr_data[2:0];
        om_a <= wr_data[4:3];
        om_b <= wr_data[6:5];
      end
      if (wr_en && wr_sel == 3'd4) mask <= wr_data[2:0];

      if (load) begin
        act_a <= buf_a;
        act_b <= buf_b;
      end
      if (wr_en && wr_sel == 3'd1) begin
        buf_a <= wr_data;
        if (!pwm) act_a <= wr_data;
      end
      if (wr_en && wr_sel == 3'd2) begin
        buf_b <= wr_data;
        if (!pwm) act_b <= wr_data;
      end

      q_a <= pin_next(q_a, om_a, hit_a, wrap, down, is_pc, is_fast);
      q_b <= pin_next(q_b, om_b, hit_b, wrap, down, is_pc, is_fast);

      flg <= (flg & ~(clr_en ? clr_bits : 3'b000)) | {hit_b, hit_a, ovf_ev};
    end
  end

  assign count = cnt;
  assign flags = flg;
  assign irq   = |(flg & mask);
  assign out_a = q_a & (om_a[1] | (om_a == 2'b01 && is_np));
  assign out_b = q_b & (om_b[1] | (om_b == 2'b01 && is_np));
endmodule

// File: rtl/wavetimer8_chk.sv
module wavetimer8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wr_en,
  input logic [W-1:0] count,
  input logic [2:0]   flags,
  input logic         irq,
  input logic [2:0]   mode,
  input logic [W-1:0] act_a
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(count));

  p_ctc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && tick && !wr_en && count == act_a) |=> (count == '0));

  p_fast_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && tick && !wr_en && count == '1) |=> (count == '0 && flags[0]));

  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd4 || mode == 3'd6) && !wr_en) |=> ($stable(count) && !$rose(flags[0])));

  p_flag_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ~$past(flags))) |-> $past(tick));

  p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 3'b000) |-> !irq);
endmodule

bind wavetimer8 wavetimer8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .count(count),
  .flags(flags), .irq(irq), .mode(mode), .act_a(act_a)
);

// File: tb/tb_wavetimer8.sv
module tb_wavetimer8;
  localparam int CLK_P = 10;
  localparam int NV = 17;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, clr_en = 1'b0;
  logic [2:0] wr_sel = '0, clr_bits = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count;
  logic       out_a, out_b, irq;
  logic [2:0] flags;
  int nchk = 0, nfail = 0;

  wavetimer8 #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .clr_en(clr_en), .clr_bits(clr_bits), .count(count),
    .out_a(out_a), .out_b(out_b), .flags(flags), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // {ctrl, cmp A, cmp B, ticks, expected count, expected flags}
  localparam logic [50:0] TBL [NV] = '{
    {8'h00, 8'd10,  8'd20,  16'd5,   8'd5,   3'b000},
    {8'h00, 8'd3,   8'd200, 16'd5,   8'd5,   3'b010},
    {8'h00, 8'd3,   8'd200, 16'd256, 8'd0,   3'b111},
    {8'h02, 8'd4,   8'd2,   16'd5,   8'd0,   3'b110},
    {8'h02, 8'd4,   8'd2,   16'd7,   8'd2,   3'b110},
    {8'h03, 8'd100, 8'd50,  16'd256, 8'd0,   3'b111},
    {8'h03, 8'd100, 8'd50,  16'd255, 8'd255, 3'b110},
    {8'h07, 8'd9,   8'd3,   16'd10,  8'd0,   3'b111},
    {8'h07, 8'd9,   8'd3,   16'd9,   8'd9,   3'b100},
    {8'h05, 8'd4,   8'd2,   16'd4,   8'd4,   3'b100},
    {8'h05, 8'd4,   8'd2,   16'd6,   8'd2,   3'b110},
    {8'h05, 8'd4,   8'd2,   16'd8,   8'd0,   3'b110},
    {8'h05, 8'd4,   8'd2,   16'd9,   8'd1,   3'b111},
    {8'h01, 8'd2,   8'd1,   16'd256, 8'd254, 3'b110},
    {8'h01, 8'd2,   8'd1,   16'd511, 8'd1,   3'b111},
    {8'h04, 8'd3,   8'd1,   16'd20,  8'd0,   3'b000},
    {8'h06, 8'd3,   8'd1,   16'd20,  8'd0,   3'b000}
  };

  function automatic string mtag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd2: return "R3";
      3'd3, 3'd7: return "R4";
      3'd1, 3'd5: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic clr(input logic [2:0] bits);
    @(negedge clk); clr_en = 1'b1; clr_bits = bits;
    @(negedge clk); clr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic setup(input logic [7:0] ctrl, input logic [7:0] a, input logic [7:0] b);
    wr(3'd3, 8'h00); wr(3'd1, a); wr(3'd2, b); wr(3'd3, ctrl); wr(3'd0, 8'h00); clr(3'b111);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog all actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", count, 0); chk("R1 flags", flags, 0);
    chk("R1 pins", {out_a, out_b}, 0); chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count after release", count, 0);

    for (int i = 0; i < NV; i++) begin
      setup(TBL[i][50:43], TBL[i][42:35], TBL[i][34:27]);
      ticks(int'(TBL[i][26:11]));
      chk({mtag(TBL[i][45:43]), " count"}, count, TBL[i][10:3]);
      chk({mtag(TBL[i][45:43]), " R14 flags"}, flags, TBL[i][2:0]);
    end

    // R2 hold without tick
    setup(8'h00, 8'd50, 8'd60); wr(3'd0, 8'd9);
    repeat (5) @(negedge clk);
    chk("R2 hold", count, 9);

    // R10 reserved with nonzero count
    wr(3'd3, 8'h04); wr(3'd0, 8'd7); ticks(5);
    chk("R10 hold", count, 7);

    // R6 immediate in free-running mode
    setup(8'h00, 8'd50, 8'd60); wr(3'd0, 8'd5); wr(3'd1, 8'd7); ticks(3);
    chk("R6 immediate", flags[1], 1);

    // R6 single-slope buffered until wrap
    setup(8'h03, 8'd10, 8'd250); ticks(5); wr(3'd1, 8'd200); ticks(10);
    chk("R6 old A still active", flags[1], 1);
    clr(3'b111); ticks(241);
    chk("R6 wrap count", count, 0);
    clr(3'b111); ticks(15);
    chk("R6 new A not yet hit", flags[1], 0);
    ticks(186);
    chk("R6 new A hit", flags[1], 1);

    // R6 dual-slope buffered until TOP
    setup(8'h05, 8'd6, 8'd250); wr(3'd0, 8'd2); wr(3'd1, 8'd3); ticks(5);
    chk("R6 old TOP used", count, 5);
    ticks(9);
    chk("R6 new TOP used", count, 2);

    // R7 non-PWM pins
    setup(8'h1A, 8'd3, 8'd250); ticks(4);
    chk("R7 set", out_a, 1);
    wr(3'd3, 8'h12); ticks(4);
    chk("R7 clear", out_a, 0);
    wr(3'd3, 8'h1A); ticks(4);
    chk("R7 set again", out_a, 1);
    wr(3'd3, 8'h02);
    chk("R7 disconnected", out_a, 0);
    wr(3'd3, 8'h1A);
    chk("R7 state kept", out_a, 1);
    wr(3'd3, 8'h0A);
    chk("R7 toggle field shows state", out_a, 1);
    ticks(4);
    chk("R7 toggle 1", out_a, 0);
    ticks(4);
    chk("R7 toggle 2", out_a, 1);
    wr(3'd3, 8'h0B);
    chk("R8 toggle field in PWM drives 0", out_a, 0);

    // R8 single-slope pins on channel B
    setup(8'h47, 8'd7, 8'd2); ticks(8);
    chk("R8 R14 set at TOP", out_b, 1); chk("R4 wrap", count, 0);
    ticks(2);
    chk("R8 before match", out_b, 1);
    ticks(1);
    chk("R8 cleared on match", out_b, 0);
    wr(3'd3, 8'h67); ticks(5);
    chk("R8 inverted clear at TOP", out_b, 0);
    ticks(3);
    chk("R8 inverted set on match", out_b, 1);

    // R9 dual-slope pins
    setup(8'h45, 8'd4, 8'd2); ticks(3);
    chk("R9 rising match clears", out_b, 0);
    ticks(4);
    chk("R9 falling match sets", out_b, 1); chk("R5 falling count", count, 1);

    // R11 write-1-to-clear and priority
    setup(8'h00, 8'd5, 8'd2); ticks(6); wr(3'd0, 8'hFF); ticks(1);
    chk("R11 all set", flags, 3'b111);
    clr(3'b001);
    chk("R11 partial clear", flags, 3'b110);
    wr(3'd0, 8'd5); clr(3'b111);
    @(negedge clk); tick = 1'b1; clr_en = 1'b1; clr_bits = 3'b110;
    @(negedge clk); tick = 1'b0; clr_en = 1'b0;
    chk("R11 set wins", flags, 3'b010);

    // R12 interrupt masking
    wr(3'd4, 8'h02);
    chk("R12 R14 masked on", irq, 1);
    wr(3'd4, 8'h01);
    chk("R12 masked off", irq, 0);
    clr(3'b111); wr(3'd4, 8'h07);
    chk("R12 no flags", irq, 0);
    wr(3'd0, 8'hFF); ticks(1);
    chk("R12 overflow raises", irq, 1);

    // R13 count write beats tick
    setup(8'h00, 8'd3, 8'd250); wr(3'd0, 8'd3); clr(3'b111);
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'd50; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    chk("R13 loaded", count, 50); chk("R13 no flag", flags, 0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule